// File: doc/BRIEF.md
# SIMD Rounding Variable Shifter

This block shifts each element of a 128-bit data vector by an amount that is set separately for every element. A second 128-bit vector carries the amounts. Both vectors are cut into lanes of equal width: 8, 16, 32 or 64 bits, picked by a two-bit size select. A mode bit chooses whether the lanes are treated as signed or unsigned.

A positive amount shifts the element toward the most significant end. A negative amount shifts it toward the least significant end and then adds back the last bit that fell off, so right shifts round half up. Amounts beyond the lane width give zero. The zeroing threshold for right shifts differs between signed and unsigned lanes.

The result is registered. An input valid pulse gives the result one clock later, together with an output valid. Typical use is as the execution stage of a vector unit that issues one rounding-shift operation per cycle.

Top module: `rsh_vec_shifter`

## Requirements
- R1: The size select uses 0 for 8-bit lanes, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Lane i of width W occupies bits [i*W +: W] of the data, the count vector and the result alike.
- R2: The shift amount of a lane is the low 8 bits of that lane of the count vector, read as a two's-complement number from -128 to +127. All higher count bits of the lane have no effect on the result.
- R3: For an amount n with 0 <= n < W, the lane result is the element shifted left by n with zeros filled in, truncated to W bits.
- R4: For a non-negative amount n >= W, the lane result is zero in both modes.
- R5: For a negative amount with magnitude m < W, the lane result is the element shifted right by m (arithmetic in signed mode, logical in unsigned mode) plus bit m-1 of the element, wrapping within W bits with no saturation.
- R6: In unsigned mode, an amount of exactly -W gives a lane result equal to the element's most significant bit (value 0 or 1).
- R7: In unsigned mode a negative amount with magnitude greater than W gives zero. In signed mode a negative amount with magnitude W or more gives zero.
- R8: The result and out_valid update one clock after a cycle with in_valid high. In a cycle after in_valid is low, out_valid is low and the result holds its previous value.
- R9: Synchronous active-high reset clears out_valid and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| data_i | input | 128 | Element vector |
| count_i | input | 128 | Per-lane shift amount vector |
| esize_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| signed_i | input | 1 | 1 selects signed lanes, 0 unsigned |
| out_valid | output | 1 | Result is valid |
| result_o | output | 128 | Shifted result vector |

## Verification
The assertions watch lane 0 on every cycle: its zeroing on oversize left and right amounts, the most-significant-bit-only result at exactly minus the width, the one-cycle valid timing and hold, and the reset state. The values of in-range shifts and their rounding, the independence of lanes, and the masking of the upper count bits appear only in the bench sweep. That sweep gives every lane of every size and mode its own boundary amount and compares it against an arithmetic model.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

    localparam int VEC_W = 128;
    localparam int CNT_W = 8;
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_B16 = 2'd1,
        ESZ_B32 = 2'd2,
        ESZ_B64 = 2'd3
    } esize_e;

    typedef struct packed {
        logic [VEC_W-1:0] data;
        logic [VEC_W-1:0] cnt;
        esize_e           esz;
        logic             sgn;
    } shift_op_s;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } shift_res_s;

    function automatic logic [VEC_W-1:0] lane0_mask(input logic [1:0] esz);
        logic [VEC_W-1:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < (8 << esz)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rsh_lane.sv
module rsh_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] elem,
    input  logic [7:0]   amt,
    input  logic         sgn,
    output logic [W-1:0] res
);
    localparam logic [8:0] WL = 9'(W);

    logic [8:0]   mag;
    logic [W-1:0] shr;
    logic [W-1:0] rbit;
    logic [W-1:0] lsh;

    always_comb begin
        mag  = 9'd0 - {amt[7], amt};
        rbit = '0;
        rbit[0] = (mag != 9'd0 && mag <= WL) ? elem[7'(mag - 9'd1)] : 1'b0;
        lsh  = elem << amt[6:0];
        if (sgn) shr = W'($signed(elem) >>> mag);
        else     shr = elem >> mag;
    end

    always_comb begin
        if (!amt[7]) begin
            res = ({1'b0, amt} >= WL) ? '0 : lsh;
        end else if (sgn) begin
            res = (mag >= WL) ? '0 : shr + rbit;
        end else if (mag > WL) begin
            res = '0;
        end else if (mag == WL) begin
            res = rbit;
        end else begin
            res = shr + rbit;
        end
    end
endmodule

// File: rtl/rsh_slice.sv
module rsh_slice
    import rsh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [VEC_W-1:0] data,
    input  logic [VEC_W-1:0] cnt,
    input  logic             sgn,
    output logic [VEC_W-1:0] res
);
    localparam int NL = VEC_W / W;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        rsh_lane #(.W(W)) u_lane (
            .elem (data[l*W +: W]),
            .amt  (cnt[l*W +: 8]),
            .sgn  (sgn),
            .res  (res[l*W +: W])
        );
    end
endmodule

// File: rtl/rsh_vec_shifter.sv
module rsh_vec_shifter
    import rsh_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] data_i,
    input  logic [127:0] count_i,
    input  logic [1:0]   esize_i,
    input  logic         signed_i,
    output logic         out_valid,
    output logic [127:0] result_o
);
    shift_op_s        op;
    shift_res_s       q;
    logic [VEC_W-1:0] cand [NUM_SIZES];
    logic [VEC_W-1:0] sel;

    assign op = '{data: data_i, cnt: count_i, esz: esize_e'(esize_i), sgn: signed_i};

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        rsh_slice #(.W(8 << g)) u_slice (
            .data (op.data),
            .cnt  (op.cnt),
            .sgn  (op.sgn),
            .res  (cand[g])
        );
    end

    always_comb begin
        unique case (op.esz)
            ESZ_B8:  sel = cand[0];
            ESZ_B16: sel = cand[1];
            ESZ_B32: sel = cand[2];
            default: sel = cand[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) q.res <= sel;
        end
    end

    assign out_valid = q.vld;
    assign result_o  = q.res;
endmodule

// File: rtl/rsh_vec_shifter_chk.sv
module rsh_vec_shifter_chk
    import rsh_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] data_i,
    input logic [127:0] count_i,
    input logic [1:0]   esize_i,
    input logic         signed_i,
    input logic         out_valid,
    input logic [127:0] result_o
);
    logic [8:0]   lw;
    logic [7:0]   cnt0;
    logic [8:0]   mag;
    logic [6:0]   msb_idx;
    logic         msb0;
    logic [127:0] mask;

    always_comb begin
        lw      = 9'd8 << esize_i;
        cnt0    = count_i[7:0];
        mag     = 9'd0 - {cnt0[7], cnt0};
        msb_idx = 7'(lw - 9'd1);
        msb0    = data_i[msb_idx];
        mask    = lane0_mask(esize_i);
    end

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && result_o == '0));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result_o)));

    assert_left_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cnt0[7] && {1'b0, cnt0} >= lw)
        |=> ((result_o & $past(mask)) == '0));

    assert_right_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt0[7] && ((signed_i && mag >= lw) || (!signed_i && mag > lw)))
        |=> ((result_o & $past(mask)) == '0));

    assert_msb_round_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt0[7] && !signed_i && mag == lw)
        |=> (result_o[0] == $past(msb0) && ((result_o & $past(mask)) >> 1) == '0));
endmodule

bind rsh_vec_shifter rsh_vec_shifter_chk u_chk (.*);

// File: tb/test_rsh_vec_shifter.sv
module test_rsh_vec_shifter;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] data_i = '0;
    logic [127:0] count_i = '0;
    logic [1:0]   esize_i = '0;
    logic         signed_i = 1'b0;
    logic         out_valid;
    logic [127:0] result_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsh_vec_shifter i_rsh_vec_shifter (.*);

    // arithmetic model: rounding by adding half an LSB before the shift
    function automatic logic [63:0] model(input logic [63:0] e, input int w,
                                          input int n, input bit sg);
        logic signed [131:0] x, r;
        logic [63:0] out;
        x = '0;
        for (int b = 0; b < 64; b++) if (b < w) x[b] = e[b];
        if (sg && e[w-1]) for (int b = 0; b < 132; b++) if (b >= w) x[b] = 1'b1;
        if (n >= 0) begin
            r = x << n;
        end else if (sg && -n >= w) begin
            r = '0;
        end else begin
            r = (x + (132'sd1 <<< (-n - 1))) >>> (-n);
        end
        out = '0;
        for (int b = 0; b < 64; b++) if (b < w) out[b] = r[b];
        return out;
    endfunction

    function automatic string tag(input int w, input int n, input bit sg);
        if (n >= 0) return (n >= w) ? "R4" : "R3";
        if (!sg && -n == w) return "R6";
        if ((sg && -n >= w) || (!sg && -n > w)) return "R7";
        return "R5";
    endfunction

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int counts[12];
        logic [63:0] exp_lane [16];
        int      n_lane [16];
        logic [127:0] exp_vec;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset out_valid", {127'd0, out_valid}, '0);
        check("R9 reset result", result_o, '0);

        for (int ez = 0; ez < 4; ez++) begin
            int w = 8 << ez;
            int nl = 128 / w;
            counts = '{0, 1, w-1, w, w+1, 127, -1, -(w-1), -w, -(w+1), -128, -2};
            for (int sg = 0; sg < 2; sg++) begin
                for (int k = 0; k < 12; k++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [127:0] d, c;
                        for (int i = 0; i < 4; i++) begin
                            d[i*32 +: 32] = $urandom;
                            c[i*32 +: 32] = $urandom;
                        end
                        if (p == 0) d = '1;
                        if (p == 1) d = {64{2'b10}};
                        for (int l = 0; l < nl; l++) begin
                            int n = counts[(l + k) % 12];
                            logic [63:0] e;
                            c[l*w +: 8] = 8'(n);
                            n_lane[l] = n;
                            e = '0;
                            for (int b = 0; b < 64; b++) if (b < w) e[b] = d[l*w + b];
                            if (p == 2) begin
                                e[w-1] = 1'b1;
                                for (int b = 0; b < 64; b++) if (b < w) d[l*w + b] = e[b];
                            end
                            exp_lane[l] = model(e, w, n, sg[0]);
                        end
                        in_valid = 1'b1;
                        data_i   = d;
                        count_i  = c;
                        esize_i  = 2'(ez);
                        signed_i = sg[0];
                        @(negedge clk);
                        in_valid = 1'b0;
                        check("R8 out_valid after in_valid", {127'd0, out_valid}, 128'd1);
                        exp_vec = '0;
                        for (int l = 0; l < nl; l++) begin
                            for (int b = 0; b < 64; b++) if (b < w) exp_vec[l*w + b] = exp_lane[l][b];
                            begin
                                logic [63:0] a;
                                a = '0;
                                for (int b = 0; b < 64; b++) if (b < w) a[b] = result_o[l*w + b];
                                check($sformatf("R1 R2 %s w=%0d s=%0d n=%0d lane=%0d",
                                      tag(w, n_lane[l], sg[0]), w, sg, n_lane[l], l),
                                      {64'd0, a}, {64'd0, exp_lane[l]});
                            end
                        end
                        if (k == 0 && p == 3) begin
                            held = result_o;
                            data_i  = ~data_i;
                            count_i = ~count_i;
                            @(negedge clk);
                            check("R8 out_valid low when idle", {127'd0, out_valid}, '0);
                            check("R8 result holds when idle", result_o, held);
                        end
                    end
                end
            end
        end

        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R9 reset mid-run out_valid", {127'd0, out_valid}, '0);
        check("R9 reset mid-run result", result_o, '0);
        done = 1;
        finish_run();
    end
endmodule